// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Look-Ahead Output

This block is a first-in first-out buffer that sits between two unrelated clock domains. Words are written on the write clock and read on the read clock. The read and write pointers pass between the domains as Gray code through two-flop synchronisers. The storage depth is a power of two set by a parameter. A mode input is sampled only while master reset is held. It selects one of two read behaviours until the next master reset.

In standard mode a word is taken only on request. `rd_stat` is an active-low empty flag and `wr_stat` is an active-low full flag. In look-ahead mode the oldest word is presented on `rd_data` without any request. `rd_stat` then becomes an active-low output-ready flag and `wr_stat` an active-low input-ready flag. The presented word occupies the output register, so the buffer holds one word more than its memory depth.

The read side is one state machine with four states. Standard mode uses RD_DRY (no readable word) and RD_WET (readable words). RD_DRY goes to RD_WET when the synchronised write pointer differs from the read pointer. RD_WET returns to RD_DRY when a read consumes the last visible word. Look-ahead mode uses LA_VOID (nothing presented) and LA_SHOW (a word is presented). LA_VOID goes to LA_SHOW by loading a word once memory is non-empty. LA_SHOW stays in LA_SHOW when a read is refilled from memory, and goes to LA_VOID when a read finds memory empty. The write side has WS_OPEN and WS_FULL. It enters WS_FULL on the write that fills the last free location and leaves it once a synchronised read frees space.

Top module: `dcf_fifo`

## Requirements
- R1: `mode_sel` is sampled only while `rst_n` is low: 0 selects standard mode and 1 selects look-ahead mode. Changing `mode_sel` after reset does not change the flag meanings.
- R2: After reset in standard mode, `rd_stat`=0 and `wr_stat`=1. After reset in look-ahead mode, `rd_stat`=1 and `wr_stat`=0.
- R3: Words come out in the order they were written, across pointer wrap. In standard mode `rd_data` shows the word after the read-clock edge that has `rd_en` high while `rd_stat`=1.
- R4: In standard mode `wr_stat` goes to 0 on the write-clock edge that stores the DEPTH-th unread word. Writes while `wr_stat`=0 are dropped.
- R5: In standard mode `rd_stat` goes to 0 on the edge that reads the last word. Reads while `rd_stat`=0 leave `rd_data` and the contents unchanged.
- R6: In standard mode, after a write into an empty buffer, `rd_stat` rises between 2 and 4 read-clock edges after the write edge.
- R7: After a read frees space in a full buffer, the full indication on `wr_stat` releases between 2 and 4 write-clock edges after the read edge.
- R8: In look-ahead mode, a word written into an empty buffer appears on `rd_data` with `rd_stat`=0 between 2 and 4 read-clock edges after the write edge, with no `rd_en`.
- R9: In look-ahead mode, a read of the last presented word sets `rd_stat`=1 on that edge and leaves `rd_data` unchanged. Reads while `rd_stat`=1 are ignored and skip no later word.
- R10: In look-ahead mode `wr_stat` becomes 1 only when DEPTH words are in memory besides the presented word (DEPTH+1 in total). Writes while `wr_stat`=1 are dropped.
- R11: Each pointer's Gray code changes by at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| rd_clk | input | 1 | Read clock |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Output register |
| rst_n | input | 1 | Master reset, active low, sampled synchronously in each domain |
| mode_sel | input | 1 | Mode choice sampled during reset (1 = look-ahead) |
| rd_stat | output | 1 | Empty flag (standard) or output-ready flag (look-ahead), active low |
| wr_stat | output | 1 | Full flag (standard) or input-ready flag (look-ahead), active low |

## Verification
Some properties are checked on every cycle:
- Refused writes and reads leave the pointers and the output register still.
- The occupancy seen from either side never exceeds the depth.
- A presented word holds until it is read.
- Each Gray pointer steps by at most one bit per clock.

Other behaviour can only be shown by the bench scenarios. These cover flag latency windows across the crossing, the DEPTH versus DEPTH+1 capacity, and data order through a wrap. They also show that a read on an empty look-ahead buffer skips no word and that the mode stays fixed after reset.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    typedef enum logic {MODE_STD = 1'b0, MODE_LA = 1'b1} fifo_mode_e;
    typedef enum logic [1:0] {RD_DRY, RD_WET, LA_VOID, LA_SHOW} rd_state_e;
    typedef enum logic {WS_OPEN, WS_FULL} wr_state_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_s,
    output logic          wr_push,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          wr_stat
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH = PW'(1 << AW);

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    fifo_mode_e    mode_q;
    wr_state_e     st, st_nx;
    logic [PW-1:0] wptr, wptr_nx, rsync;

    assign rsync   = g2b(rgray_s);
    assign wr_push = wr_en && (st == WS_OPEN);
    assign wptr_nx = wptr + PW'(wr_push);
    assign waddr   = wptr[AW-1:0];

    always_ff @(posedge wr_clk) begin
        if (!rst_n) mode_q <= fifo_mode_e'(mode_sel);
    end

    // state register
    always_ff @(posedge wr_clk) begin
        if (!rst_n) st <= WS_OPEN;
        else        st <= st_nx;
    end

    always_comb begin
        unique case (st)
            WS_OPEN: st_nx = ((wptr_nx - rsync) == DEPTH) ? WS_FULL : WS_OPEN;
            WS_FULL: st_nx = ((wptr - rsync) == DEPTH) ? WS_FULL : WS_OPEN;
            default: st_nx = WS_OPEN;
        endcase
    end

    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else begin
            wptr  <= wptr_nx;
            wgray <= wptr_nx ^ (wptr_nx >> 1);
        end
    end

    // outputs
    always_comb begin
        unique case (mode_q)
            MODE_LA:  wr_stat = (st == WS_FULL);
            default:  wr_stat = (st == WS_OPEN);
        endcase
    end

    // R4
    full_block_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (st == WS_FULL && wr_en) |=> $stable(wptr));
    // R10
    occ_bound_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ((wptr - rsync) <= DEPTH));
    // R11
    wgray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ($countones(wgray ^ $past(wgray)) <= 1));
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] rd_data,
    output logic          rd_stat
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH = PW'(1 << AW);

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    rd_state_e     st, st_nx;
    logic [PW-1:0] rptr, rptr_nx, wsync;
    logic          take, mem_has, has_after;

    assign wsync     = g2b(wgray_s);
    assign mem_has   = (wsync != rptr);
    assign rptr_nx   = rptr + PW'(take);
    assign has_after = (wsync != rptr_nx);
    assign raddr     = rptr[AW-1:0];

    // state register
    always_ff @(posedge rd_clk) begin
        if (!rst_n) st <= mode_sel ? LA_VOID : RD_DRY;
        else        st <= st_nx;
    end

    always_comb begin
        unique case (st)
            RD_DRY:  st_nx = has_after ? RD_WET : RD_DRY;
            RD_WET:  st_nx = has_after ? RD_WET : RD_DRY;
            LA_VOID: st_nx = mem_has ? LA_SHOW : LA_VOID;
            LA_SHOW: st_nx = (rd_en && !mem_has) ? LA_VOID : LA_SHOW;
            default: st_nx = RD_DRY;
        endcase
    end

    // outputs
    always_comb begin
        unique case (st)
            RD_DRY:  begin take = 1'b0;               rd_stat = 1'b0; end
            RD_WET:  begin take = rd_en;              rd_stat = 1'b1; end
            LA_VOID: begin take = mem_has;            rd_stat = 1'b1; end
            LA_SHOW: begin take = rd_en && mem_has;   rd_stat = 1'b0; end
            default: begin take = 1'b0;               rd_stat = 1'b0; end
        endcase
    end

    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rptr    <= '0;
            rgray   <= '0;
            rd_data <= '0;
        end else begin
            rptr  <= rptr_nx;
            rgray <= rptr_nx ^ (rptr_nx >> 1);
            if (take) rd_data <= mem_q;
        end
    end

    // R5
    dry_block_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (st == RD_DRY && rd_en) |=> ($stable(rptr) && $stable(rd_data)));
    // R9
    show_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (st == LA_SHOW && !rd_en) |=> $stable(rd_data));
    // R9
    void_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (st == LA_VOID && !mem_has) |=> $stable(rd_data));
    // R3
    rd_behind_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        ((wsync - rptr) <= DEPTH));
    // R11
    rgray_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        ($countones(rgray ^ $past(rgray)) <= 1));
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          wr_clk,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clk,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          rst_n,
    input  logic          mode_sel,
    output logic          rd_stat,
    output logic          wr_stat
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] mem_q;
    logic [AW-1:0] waddr, raddr;
    logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
    logic          wr_push;

    always_ff @(posedge wr_clk) begin
        if (wr_push) mem[waddr] <= wr_data;
    end
    assign mem_q = mem[raddr];

    dcf_wr_ctrl #(.AW(AW)) u_wr (
        .wr_clk(wr_clk), .rst_n(rst_n), .mode_sel(mode_sel), .wr_en(wr_en),
        .rgray_s(rgray_s), .wr_push(wr_push), .waddr(waddr), .wgray(wgray),
        .wr_stat(wr_stat)
    );

    dcf_rd_ctrl #(.AW(AW), .DW(DW)) u_rd (
        .rd_clk(rd_clk), .rst_n(rst_n), .mode_sel(mode_sel), .rd_en(rd_en),
        .wgray_s(wgray_s), .mem_q(mem_q), .raddr(raddr), .rgray(rgray),
        .rd_data(rd_data), .rd_stat(rd_stat)
    );

    dcf_sync #(.W(AW + 1)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
    dcf_sync #(.W(AW + 1)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));
endmodule

// File: tb/tb_dcf_fifo.sv
module tb_dcf_fifo;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam int DEPTH = 1 << AW;
    // entry = {expected wr_stat after the write, data}
    localparam logic [8:0] VEC [8] = '{9'h1A5, 9'h13C, 9'h101, 9'h1FE,
                                        9'h180, 9'h17F, 9'h155, 9'h0C3};

    logic wr_clk = 0, rd_clk = 0, wr_en = 0, rd_en = 0, rst_n = 0, mode_sel = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic rd_stat, wr_stat;
    int checks = 0, fails = 0, wcyc = 0, rcyc = 0, wmark = 0, rmark = 0;

    dcf_fifo #(.DW(DW), .AW(AW)) dut (
        .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data), .rd_clk(rd_clk),
        .rd_en(rd_en), .rd_data(rd_data), .rst_n(rst_n), .mode_sel(mode_sel),
        .rd_stat(rd_stat), .wr_stat(wr_stat)
    );

    always #5 wr_clk = ~wr_clk;
    initial begin #2; forever #5 rd_clk = ~rd_clk; end
    always @(posedge wr_clk) wcyc++;
    always @(posedge rd_clk) rcyc++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_win(input string req, input int n);
        checks++;
        if (n < 2 || n > 4) begin
            fails++;
            $display("FAIL %s actual=%0d expected=2..4", req, n);
        end
    endtask

    task automatic do_reset(input logic m);
        @(negedge wr_clk);
        rst_n = 0; mode_sel = m; wr_en = 0; rd_en = 0;
        repeat (4) @(negedge wr_clk);
        rst_n = 1;
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge wr_clk); wr_en = 1; wr_data = d;
        @(posedge wr_clk); wmark = rcyc;
        @(negedge wr_clk); wr_en = 0;
    endtask

    task automatic pop;
        @(negedge rd_clk); rd_en = 1;
        @(posedge rd_clk); rmark = wcyc;
        @(negedge rd_clk); rd_en = 0;
    endtask

    task automatic wait_rd(input logic tgt, output int n);
        int k = 0;
        while (rd_stat !== tgt && k < 20) begin @(negedge rd_clk); k++; end
        n = rcyc - wmark;
    endtask

    task automatic wait_wr(input logic tgt, output int n);
        int k = 0;
        while (wr_stat !== tgt && k < 20) begin @(negedge wr_clk); k++; end
        n = wcyc - rmark;
    endtask

    initial begin
        repeat (20000) @(posedge wr_clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        // ---------------- standard mode ----------------
        do_reset(1'b0);
        mode_sel = 1'b1;  // R1: ignored after reset
        @(negedge rd_clk);
        chk("R2 std rd_stat", rd_stat, 0);
        chk("R2 std wr_stat", wr_stat, 1);
        for (int i = 0; i < 8; i++) begin
            push(VEC[i][7:0]);
            chk("R4 full flag", wr_stat, VEC[i][8]);
        end
        push(8'hEE);  // dropped while full
        chk("R4 stays full", wr_stat, 0);
        wait_rd(1'b1, n);
        for (int i = 0; i < 8; i++) begin
            pop;
            chk("R3 order", rd_data, VEC[i][7:0]);
        end
        chk("R5 empty after last", rd_stat, 0);
        chk("R1 std kept", rd_stat, 0);
        pop;  // ignored
        chk("R5 data held", rd_data, 8'hC3);
        chk("R5 still empty", rd_stat, 0);
        // R11: pointers now wrap past the depth
        push(8'h5A);
        wait_rd(1'b1, n);
        chk_win("R6 empty release", n);
        pop;
        chk("R3 wrap R11", rd_data, 8'h5A);
        for (int i = 0; i < DEPTH; i++) push(8'(8'h10 + i));
        chk("R4 full again", wr_stat, 0);
        wait_rd(1'b1, n);
        pop;
        chk("R3 after wrap", rd_data, 8'h10);
        wait_wr(1'b1, n);
        chk_win("R7 full release", n);

        // ---------------- look-ahead mode ----------------
        do_reset(1'b1);
        mode_sel = 1'b0;  // R1: ignored after reset
        @(negedge rd_clk);
        chk("R2 la rd_stat", rd_stat, 1);
        chk("R2 la wr_stat", wr_stat, 0);
        push(8'h77);
        wait_rd(1'b0, n);
        chk_win("R8 fall-through latency", n);
        chk("R8 word shown", rd_data, 8'h77);
        chk("R1 la kept", rd_stat, 0);
        pop;
        chk("R9 not ready", rd_stat, 1);
        chk("R9 data stays", rd_data, 8'h77);
        pop;  // ignored
        chk("R9 ignored read", rd_data, 8'h77);
        push(8'h78);
        wait_rd(1'b0, n);
        chk("R9 no skip", rd_data, 8'h78);
        repeat (6) @(negedge wr_clk);
        for (int i = 0; i < DEPTH; i++) begin
            push(8'(8'h90 + i));
            if (i == DEPTH - 2) chk("R10 still ready", wr_stat, 0);
        end
        chk("R10 full at depth+1", wr_stat, 1);
        push(8'hEE);  // dropped
        wait_rd(1'b0, n);
        chk("R10 head", rd_data, 8'h78);
        pop;
        for (int i = 0; i < DEPTH; i++) begin
            wait_rd(1'b0, n);
            chk("R10 order", rd_data, 8'(8'h90 + i));
            pop;
        end
        repeat (8) @(negedge rd_clk);
        chk("R9 drained", rd_stat, 1);
        chk("R10 dropped word absent", rd_data, 8'h97);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule